// File: doc/BRIEF.md
# Line-Buffered Field Memory Write Port

This block is the write side of a field memory that is accessed one line at a time. Pixel words arrive on the write clock. Each word is stored in a one-line staging register at the position given by an internal word pointer. A separate line pointer selects the destination line in an external line-addressed storage array. The staging register reaches the array only when an explicit transfer command is given. The transfer then runs as a burst of one array strobe per word.

The destination line can be chosen in two ways. It can be loaded serially, one address bit per clock. It can also be moved with single-cycle commands: clear to the origin, step to the next line, or jump back to the most recently loaded address. That address is held in a preset register that survives clears and increments. A write-enable input gates pointer movement. An input-mask input lets the pointer skip words while leaving their staged contents untouched, which is how picture-in-picture windows are written.

Default geometry is 768 words per line, 290 lines and 12-bit words. The line address width is derived from the line count, which gives 9 bits at the defaults.

Top module: `fm_write_port`

## Requirements
- R1: While rst_ni is low, and right after it is released, line_o and word_o read 0, busy_o is low and arr_we_o is low.
- R2: With cmd_i low and ade_i high, each clock shifts addr_bit_i into the preset register, most significant bit first. The line pointer takes the shifted value, the word pointer goes to 0, and nothing is staged. After LW such cycles, line_o equals the serially sent address.
- R3: With cmd_i low, ade_i low, we_i high and ie_i high, data_i is staged at word word_o and the word pointer advances by one.
- R4: With cmd_i low, ade_i low, we_i high and ie_i low, the word pointer advances and the staged word at that position keeps its earlier value.
- R5: With cmd_i low, ade_i low and we_i low, both pointers hold and nothing is staged, whatever the level of ie_i.
- R6: The word pointer saturates at WORDS-1. Further enabled writes land on word WORDS-1.
- R7: With cmd_i high, inc_i low and ade_i low (transfer), a burst starts on the next cycle. busy_o stays high for exactly WORDS cycles. Each of those cycles drives arr_we_o with arr_word_o = 0, 1, …, WORDS-1 in turn, arr_line_o equal to the line pointer at the command, and arr_data_o equal to the staged word.
- R8: With cmd_i high, ade_i high and inc_i low (clear), both pointers go to 0 and the preset register is kept.
- R9: With cmd_i high, inc_i high and ade_i low (line increment), the line pointer goes to line+1, wrapping from LINES-1 to 0, and the word pointer goes to 0.
- R10: With cmd_i, inc_i and ade_i all high (jump), the line pointer goes to the preset register's value and the word pointer goes to 0.
- R11: A command cycle (cmd_i high) never stages data. A transfer command leaves both pointers unchanged, even with we_i high.
- R12: While busy_o is high, enabled writes still move the word pointer but stage nothing, and further transfer commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable; gates pointer advance |
| ie_i | input | 1 | Input enable; low masks staging |
| data_i | input | DW | Pixel word |
| cmd_i | input | 1 | Command cycle select |
| inc_i | input | 1 | Command code bit: increment |
| ade_i | input | 1 | Address enable / command code bit |
| addr_bit_i | input | 1 | Serial line address bit |
| line_o | output | LW | Current line pointer |
| word_o | output | WW | Current word pointer |
| busy_o | output | 1 | Transfer burst in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_line_o | output | LW | Array line index |
| arr_word_o | output | WW | Array word index |
| arr_data_o | output | DW | Array write data |

## Verification
The bench uses an 8-word, 5-line configuration and checks the pointers after every cycle against an arithmetic model.

Masked words are checked after a second transfer, where they must still hold values from an earlier line. A design that wrote through the mask would corrupt them.

Saturation is checked by writing past the last word. A design that wrapped the pointer would overwrite word 0 instead of the last word.

The line increment is checked at the last line, where a design that forgot to wrap would leave the array's range. A jump is issued after a clear, where a design that reset the preset register would return to line 0.

Writes and a second transfer are issued during a burst. A design that let them through would show changed array contents or extra strobes.

// File: rtl/fm_wr_pkg.sv
package fm_wr_pkg;
  typedef enum logic [2:0] {
    OP_DATA, OP_SHIFT, OP_XFER, OP_CLEAR, OP_LINC, OP_JUMP
  } op_e;

  function automatic op_e decode_op(input logic cmd, input logic inc, input logic ade);
    if (!cmd) return ade ? OP_SHIFT : OP_DATA;
    case ({inc, ade})
      2'b00:   return OP_XFER;
      2'b01:   return OP_CLEAR;
      2'b10:   return OP_LINC;
      default: return OP_JUMP;
    endcase
  endfunction
endpackage

// File: rtl/fm_addr_shift.sv
module fm_addr_shift #(
  parameter int LW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [LW-1:0] next_o,
  output logic [LW-1:0] preset_o
);
  logic [LW-1:0] preset_q;

  generate
    if (LW > 1) begin : g_wide
      assign next_o = {preset_q[LW-2:0], bit_i};
    end else begin : g_narrow
      assign next_o = bit_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      preset_q <= '0;
    else if (shift_i) preset_q <= next_o;
  end

  assign preset_o = preset_q;
endmodule

// File: rtl/fm_ptr_ctrl.sv
module fm_ptr_ctrl
  import fm_wr_pkg::*;
#(
  parameter int WORDS = 768,
  parameter int LINES = 290,
  parameter int LW    = 9,
  parameter int WW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           op_i,
  input  logic          we_i,
  input  logic [LW-1:0] shift_val_i,
  input  logic [LW-1:0] preset_i,
  output logic [LW-1:0] line_o,
  output logic [WW-1:0] word_o
);
  localparam logic [WW-1:0] LAST_WORD = WW'(WORDS - 1);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

  logic [LW-1:0] line_q, line_d;
  logic [WW-1:0] word_q, word_d;

  always_comb begin
    line_d = line_q;
    word_d = word_q;
    unique case (op_i)
      OP_SHIFT: begin line_d = shift_val_i; word_d = '0; end
      OP_CLEAR: begin line_d = '0; word_d = '0; end
      OP_LINC: begin
        line_d = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
        word_d = '0;
      end
      OP_JUMP: begin line_d = preset_i; word_d = '0; end
      OP_DATA: if (we_i && word_q != LAST_WORD) word_d = word_q + 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      word_q <= '0;
    end else begin
      line_q <= line_d;
      word_q <= word_d;
    end
  end

  assign line_o = line_q;
  assign word_o = word_q;
endmodule

// File: rtl/fm_line_buf.sv
module fm_line_buf #(
  parameter int WORDS = 768,
  parameter int DW    = 12,
  parameter int LW    = 9,
  parameter int WW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [WW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          xfer_i,
  input  logic [LW-1:0] xfer_line_i,
  output logic          busy_o,
  output logic          arr_we_o,
  output logic [LW-1:0] arr_line_o,
  output logic [WW-1:0] arr_word_o,
  output logic [DW-1:0] arr_data_o
);
  localparam logic [WW-1:0] LAST_WORD = WW'(WORDS - 1);

  logic [DW-1:0] stage_q [WORDS];
  logic          busy_q;
  logic [WW-1:0] cnt_q;
  logic [LW-1:0] line_q;

  // staging is frozen while a burst reads it
  always_ff @(posedge clk_i) begin
    if (wr_i && !busy_q) stage_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      line_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST_WORD) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (xfer_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      line_q <= xfer_line_i;
    end
  end

  assign busy_o     = busy_q;
  assign arr_we_o   = busy_q;
  assign arr_line_o = line_q;
  assign arr_word_o = cnt_q;
  assign arr_data_o = stage_q[cnt_q];
endmodule

// File: rtl/fm_write_port.sv
module fm_write_port
  import fm_wr_pkg::*;
#(
  parameter int WORDS = 768,
  parameter int LINES = 290,
  parameter int DW    = 12,
  localparam int LW   = $clog2(LINES),
  localparam int WW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          ie_i,
  input  logic [DW-1:0] data_i,
  input  logic          cmd_i,
  input  logic          inc_i,
  input  logic          ade_i,
  input  logic          addr_bit_i,
  output logic [LW-1:0] line_o,
  output logic [WW-1:0] word_o,
  output logic          busy_o,
  output logic          arr_we_o,
  output logic [LW-1:0] arr_line_o,
  output logic [WW-1:0] arr_word_o,
  output logic [DW-1:0] arr_data_o
);
  op_e           op;
  logic [LW-1:0] shift_val, preset;

  assign op = decode_op(cmd_i, inc_i, ade_i);

  fm_addr_shift #(.LW(LW)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (op == OP_SHIFT),
    .bit_i   (addr_bit_i),
    .next_o  (shift_val),
    .preset_o(preset)
  );

  fm_ptr_ctrl #(.WORDS(WORDS), .LINES(LINES), .LW(LW), .WW(WW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .we_i       (we_i),
    .shift_val_i(shift_val),
    .preset_i   (preset),
    .line_o     (line_o),
    .word_o     (word_o)
  );

  fm_line_buf #(.WORDS(WORDS), .DW(DW), .LW(LW), .WW(WW)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (op == OP_DATA && we_i && ie_i),
    .wr_idx_i   (word_o),
    .wr_data_i  (data_i),
    .xfer_i     (op == OP_XFER),
    .xfer_line_i(line_o),
    .busy_o     (busy_o),
    .arr_we_o   (arr_we_o),
    .arr_line_o (arr_line_o),
    .arr_word_o (arr_word_o),
    .arr_data_o (arr_data_o)
  );
endmodule

// File: rtl/fm_write_port_chk.sv
module fm_write_port_chk #(
  parameter int WORDS = 768,
  parameter int LINES = 290,
  parameter int LW    = 9,
  parameter int WW    = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic          cmd_i,
  input logic          inc_i,
  input logic          ade_i,
  input logic [LW-1:0] line_o,
  input logic [WW-1:0] word_o,
  input logic          busy_o,
  input logic [LW-1:0] arr_line_o,
  input logic [WW-1:0] arr_word_o
);
  localparam logic [WW-1:0] LAST_WORD = WW'(WORDS - 1);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

  assert_word_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_o <= LAST_WORD);

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_i && !ade_i && !we_i) |=> ($stable(word_o) && $stable(line_o)));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i && ade_i && !inc_i) |=> (line_o == '0 && word_o == '0));

  assert_line_inc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i && inc_i && !ade_i) |=>
      (word_o == '0 && line_o == (($past(line_o) == LAST_LINE) ? '0 : LW'($past(line_o) + 1'b1))));

  assert_xfer_ptr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i && !inc_i && !ade_i) |=> ($stable(word_o) && $stable(line_o)));

  assert_burst_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> arr_word_o == '0);

  assert_burst_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && arr_word_o != LAST_WORD) |=> (busy_o && arr_word_o == WW'($past(arr_word_o) + 1'b1)));

  assert_burst_line_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(arr_line_o)));
endmodule

bind fm_write_port fm_write_port_chk #(
  .WORDS(WORDS), .LINES(LINES), .LW(LW), .WW(WW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .cmd_i     (cmd_i),
  .inc_i     (inc_i),
  .ade_i     (ade_i),
  .line_o    (line_o),
  .word_o    (word_o),
  .busy_o    (busy_o),
  .arr_line_o(arr_line_o),
  .arr_word_o(arr_word_o)
);

// File: tb/fm_write_port_bench.sv
module fm_write_port_bench;
  localparam int PERIOD = 10;
  localparam int W  = 8;
  localparam int L  = 5;
  localparam int DW = 12;
  localparam int LW = $clog2(L);
  localparam int WW = $clog2(W);

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, ie = 0, cmd = 0, inc = 0, ade = 0, abit = 0;
  logic [DW-1:0] data = '0;
  logic [LW-1:0] line_o, arr_line;
  logic [WW-1:0] word_o, arr_word;
  logic busy, arr_we;
  logic [DW-1:0] arr_data;

  fm_write_port #(.WORDS(W), .LINES(L), .DW(DW)) u_fm_write_port (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .ie_i(ie), .data_i(data),
    .cmd_i(cmd), .inc_i(inc), .ade_i(ade), .addr_bit_i(abit),
    .line_o(line_o), .word_o(word_o), .busy_o(busy), .arr_we_o(arr_we),
    .arr_line_o(arr_line), .arr_word_o(arr_word), .arr_data_o(arr_data)
  );

  always #(PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, strobes = 0;
  logic [DW-1:0] mem [L][W];
  logic [DW-1:0] bufm [W];
  logic [DW-1:0] snap [W];
  int e_line = 0, e_word = 0, e_preset = 0, busy_left = 0;
  bit done = 0;

  // capture array writes mid-cycle
  always @(negedge clk) if (rst_n && arr_we) begin
    mem[arr_line][arr_word] = arr_data;
    strobes++;
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic w, input logic i, input logic [DW-1:0] d,
                      input logic c, input logic n, input logic a, input logic b);
    bit bsy, start;
    @(negedge clk);
    we = w; ie = i; data = d; cmd = c; inc = n; ade = a; abit = b;
    bsy = busy_left > 0;
    start = 0;
    if (!c && a) begin
      e_preset = ((e_preset << 1) | int'(b)) & ((1 << LW) - 1);
      e_line = e_preset; e_word = 0;
    end else if (c) begin
      case ({n, a})
        2'b00: if (!bsy) begin start = 1; foreach (bufm[k]) snap[k] = bufm[k]; end
        2'b01: begin e_line = 0; e_word = 0; end
        2'b10: begin e_line = (e_line == L-1) ? 0 : e_line + 1; e_word = 0; end
        default: begin e_line = e_preset; e_word = 0; end
      endcase
    end else if (w) begin
      if (i && !bsy) bufm[e_word] = d;
      if (e_word != W-1) e_word++;
    end
    if (bsy) busy_left--;
    if (start) busy_left = W;
    @(posedge clk); #1;
    chk(tag, int'(line_o), e_line, "line");
    chk(tag, int'(word_o), e_word, "word");
    chk(tag, int'(busy), int'(busy_left > 0), "busy");
  endtask

  task automatic idle(input int k);
    for (int j = 0; j < k; j++) step("R5", 1'b0, 1'b1, 12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic load(input int a);
    for (int b = LW-1; b >= 0; b--) step("R2", 1'b1, 1'b1, 12'hEEE, 1'b0, 1'b0, 1'b1, a[b]);
  endtask

  task automatic write_line(input logic [DW-1:0] base, input bit masked);
    for (int i = 0; i < W; i++) begin
      if (i == 2) step("R5", 1'b0, 1'b1, 12'hBAD, 1'b0, 1'b0, 1'b0, 1'b0);
      step(masked && (i % 3 == 1) ? "R4" : "R3", 1'b1, !(masked && (i % 3 == 1)),
           base + DW'(i * 7), 1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic check_line(input string tag, input int l);
    for (int i = 0; i < W; i++) chk(tag, int'(mem[l][i]), int'(snap[i]), $sformatf("array[%0d][%0d]", l, i));
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    foreach (mem[a, b]) mem[a][b] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", int'(line_o), 0, "line in reset");
    chk("R1", int'(word_o), 0, "word in reset");
    chk("R1", int'(busy), 0, "busy in reset");
    chk("R1", int'(arr_we), 0, "strobe in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", int'(line_o), 0, "line after reset");
    chk("R1", int'(busy), 0, "busy after reset");

    load(3);
    chk("R2", int'(line_o), 3, "serial load");
    write_line(12'h100, 0);
    for (int k = 0; k < 3; k++) step("R6", 1'b1, 1'b1, 12'hA00 + DW'(k), 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6", int'(word_o), W-1, "saturated word");

    strobes = 0;
    step("R11", 1'b1, 1'b1, 12'h555, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(W + 2);
    chk("R7", strobes, W, "strobe count");
    check_line("R7", 3);

    step("R9", 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    write_line(12'h200, 1);
    step("R7", 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(W + 2);
    check_line("R4", 4);
    chk("R4", int'(mem[4][1]), int'(mem[3][1]), "masked word kept");

    step("R8", 1'b1, 1'b1, '0, 1'b1, 1'b0, 1'b1, 1'b0);
    step("R10", 1'b1, 1'b1, '0, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R10", int'(line_o), 3, "jump to preset after clear");

    load(L-1);
    step("R9", 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R9", int'(line_o), 0, "wrap to line 0");
    step("R10", 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R10", int'(line_o), L-1, "jump to reloaded preset");

    foreach (mem[4][i]) mem[4][i] = '0;
    strobes = 0;
    step("R7", 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) step("R12", 1'b1, 1'b1, 12'h7C0 + DW'(k), 1'b0, 1'b0, 1'b0, 1'b0);
    step("R12", 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(W + 2);
    chk("R12", strobes, W, "single burst");
    check_line("R7", L-1);
    step("R12", 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(W + 2);
    check_line("R12", L-1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule